// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block is the arithmetic core of an 8-bit accumulator machine. On each accepted request it reads an operation code and several inputs: the accumulator, a second operand, the B register and the current carry, auxiliary-carry and overflow flags. It then returns a complete new state: accumulator, B, carry, auxiliary carry and overflow. Where an operation does not touch a register or flag, that output is loaded from the matching input. A parity flag is derived at all times from the registered accumulator.

The unit handles add, add with carry, subtract with borrow, decimal adjust and unsigned compare in a single cycle. Unsigned multiply and divide run iteratively, one bit per cycle. Both report completion with a one-cycle `done` pulse, and both split their result between the accumulator and B. Instruction decode and the register file live outside the block. The surrounding core presents the operands and the `start` pulse, and writes back the outputs once `done` is seen.

Top module: `alu8_unit`

## Requirements
- R1: Operation codes on `op` are 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide, 5 decimal adjust, 6 compare, and 7 pass. For add, the result is acc_in + opnd_in; for add with carry it is acc_in + opnd_in + cy_in. The low 8 bits go to acc_out and cy_out is the carry out of bit 7. B is loaded from b_in.
- R2: After add, add with carry and subtract, ac_out is the carry out of bit 3 (for subtract, the borrow out of bit 3).
- R3: After add, add with carry and subtract, ov_out is set when exactly one of the carries (or borrows) out of bit 6 and bit 7 occurs, and cleared otherwise.
- R4: par_out always equals the XOR of all acc_out bits, so acc_out plus the flag holds an even count of ones.
- R5: Subtract computes acc_in - opnd_in - cy_in. The low 8 bits go to acc_out and cy_out is the borrow out of bit 7.
- R6: Multiply forms acc_in * b_in. The high byte goes to b_out and the low byte to acc_out. ov_out is set when the product exceeds 255, cy_out is cleared, and ac_out takes ac_in.
- R7: Divide puts acc_in / b_in in acc_out and the remainder in b_out, clears cy_out and ov_out, and passes ac_in to ac_out. When b_in is zero, ov_out is set, acc_out is FFh and b_out is acc_in.
- R8: Decimal adjust works in two steps. First it adds 06h when the low nibble of acc_in is above 9 or ac_in is set. It then adds 60h when the high nibble of that intermediate is above 9, or cy_in is set, or the first step carried. cy_out is cy_in OR either step's carry out. B, ac and ov pass through.
- R9: Compare sets cy_out when acc_in < opnd_in (unsigned) and clears it otherwise. acc_out, b_out, ac_out and ov_out take acc_in, b_in, ac_in and ov_in.
- R10: Code 7 loads acc_out, b_out and all three flags straight from their inputs.
- R11: For codes other than 3 and 4, the outputs change on the clock edge that samples `start`, and `done` is high for the following cycle. A multiply or divide raises `busy` for 8 cycles; results and a one-cycle `done` appear after the ninth edge counted from the one that sampled `start`. `start` is ignored while `busy` is high, and the outputs hold during that time.
- R12: While rst_n is low, all data outputs, flags, `busy` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, sampled when not busy |
| op | input | 3 | Operation code (see R1) |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand |
| b_in | input | 8 | Current B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| ov_in | input | 1 | Current overflow flag |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |
| par_out | output | 1 | Parity of acc_out |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that every input is known (never X) on any cycle where `start` is high, because compare, add-overflow and completion properties read those inputs through $past. They also assume that a request is judged only on the cycle it is sampled, so no input needs to stay stable beyond that edge. The stimulus drives every input from the falling clock edge on every cycle after reset, with fully defined values. It also deliberately raises `start` during a multiply to exercise the ignore rule, so these assumptions always hold while new cases are still reached.

// File: rtl/alu8_pkg.sv
// Shared operation codes and flag bundle for the accumulator arithmetic unit.
// Assumes the operation code is three bits wide.
package alu8_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4,
        OP_DECA = 3'd5,
        OP_CMP  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
// Combinational adder/subtractor with carry-in and the three carry-derived flags.
// Assumes W is even; the auxiliary flag is taken from the lower half boundary.
// Carries into a bit are recovered as a ^ b ^ sum, so no partial adders are needed.
module alu8_addsub #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         c_top,
    output logic         c_aux,
    output logic         c_ov
);
    localparam int H = W / 2;

    logic [W:0] full;
    logic       into_top;

    // Full-width sum or difference with carry/borrow in.
    always_comb begin
        if (sub) full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else     full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    // Flag extraction from the carry chain.
    always_comb begin
        res      = full[W-1:0];
        c_top    = full[W];
        c_aux    = a[H] ^ b[H] ^ full[H];
        into_top = a[W-1] ^ b[W-1] ^ full[W-1];
        c_ov     = into_top ^ full[W];
    end

endmodule

// File: rtl/alu8_decadj.sv
// Combinational decimal adjust of a packed two-digit value after an addition.
// Assumes W is even; each half is treated as one decimal digit.
module alu8_decadj #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         cy_i,
    input  logic         ac_i,
    output logic [W-1:0] res,
    output logic         cy_o
);
    localparam int H = W / 2;
    localparam logic [H-1:0] DIGIT_MAX = H'(9);
    localparam logic [W:0]   LO_FIX    = (W+1)'(6);
    localparam logic [W:0]   HI_FIX    = (W+1)'(6) << H;

    logic [W:0] step1;
    logic [W:0] step2;
    logic       fix_lo;
    logic       fix_hi;

    // Two-step digit correction with carry accumulation.
    always_comb begin
        fix_lo = (a[H-1:0] > DIGIT_MAX) || ac_i;
        step1  = {1'b0, a} + (fix_lo ? LO_FIX : '0);
        fix_hi = (step1[W-1:H] > DIGIT_MAX) || cy_i || step1[W];
        step2  = {1'b0, step1[W-1:0]} + (fix_hi ? HI_FIX : '0);
        res    = step2[W-1:0];
        cy_o   = cy_i | step1[W] | step2[W];
    end

endmodule

// File: rtl/alu8_muldiv.sv
// Iterative unsigned multiplier / restoring divider, one bit per cycle, W cycles.
// Assumes go is only honoured while idle. fin marks the last step; res_hi/res_lo
// carry the final values in that cycle. Divide by zero yields an all-ones quotient
// and the dividend as remainder.
module alu8_muldiv #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         is_div,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         fin,
    output logic         div_mode,
    output logic         div_zero,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic            busy_q;
    logic            div_q;
    logic [CW-1:0]   cnt_q;
    logic [W-1:0]    mcand_q;
    logic [W-1:0]    mplier_q;
    logic [2*W-1:0]  prod_q;
    logic [W-1:0]    rem_q;
    logic [W-1:0]    quo_q;

    logic [2*W-1:0]  prod_nx;
    logic [W:0]      trial;
    logic            fits;
    logic [W-1:0]    rem_nx;
    logic [W-1:0]    quo_nx;

    // Next partial product and next division step.
    always_comb begin
        prod_nx = prod_q + (mplier_q[cnt_q] ? ({{W{1'b0}}, mcand_q} << cnt_q) : '0);
        trial   = {rem_q, mplier_q[W-1]};
        fits    = trial >= {1'b0, mcand_q};
        rem_nx  = fits ? (trial[W-1:0] - mcand_q) : trial[W-1:0];
        quo_nx  = {quo_q[W-2:0], fits};
    end

    // Sequencing and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            div_q    <= 1'b0;
            cnt_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q   <= 1'b1;
                div_q    <= is_div;
                cnt_q    <= '0;
                mcand_q  <= is_div ? opb : opa;
                mplier_q <= is_div ? opa : opb;
                prod_q   <= '0;
                rem_q    <= '0;
                quo_q    <= '0;
            end
        end else begin
            cnt_q <= cnt_q + CW'(1);
            if (div_q) begin
                rem_q    <= rem_nx;
                quo_q    <= quo_nx;
                mplier_q <= {mplier_q[W-2:0], 1'b0};
            end else begin
                prod_q <= prod_nx;
            end
            if (fin) busy_q <= 1'b0;
        end
    end

    // Status and final-step results.
    always_comb begin
        busy     = busy_q;
        fin      = busy_q && (cnt_q == CW'(W-1));
        div_mode = div_q;
        div_zero = (mcand_q == '0);
        res_hi   = div_q ? rem_nx : prod_nx[2*W-1:W];
        res_lo   = div_q ? quo_nx : prod_nx[W-1:0];
    end

endmodule

// File: rtl/alu8_unit.sv
// Accumulator arithmetic unit top. It accepts one request per start while idle,
// returns a full new accumulator/B/flag state, and pulses done when that state
// is valid. Single-cycle operations complete on the accepting edge; multiply and
// divide complete W edges later. Parity follows the registered accumulator.
module alu8_unit #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    input  logic [W-1:0] b_in,
    input  logic         cy_in,
    input  logic         ac_in,
    input  logic         ov_in,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] b_out,
    output logic         cy_out,
    output logic         ac_out,
    output logic         ov_out,
    output logic         par_out,
    output logic         busy,
    output logic         done
);
    import alu8_pkg::*;

    alu_op_e    op_e;
    logic       md_busy, md_fin, md_div, md_dz;
    logic [W-1:0] md_hi, md_lo;
    logic       accept, is_md;
    logic       as_cin, as_sub;
    logic [W-1:0] as_res, da_res;
    logic       as_ctop, as_caux, as_cov, da_cy;

    logic [W-1:0] acc_q, acc_n, b_q, b_n;
    alu_flags_t flg_q, flg_n;
    logic       ac_hold_q, ac_hold_n;
    logic       done_q, done_n;

    // Request decode.
    always_comb begin
        op_e   = alu_op_e'(op);
        is_md  = (op_e == OP_MUL) || (op_e == OP_DIV);
        accept = start && !md_busy;
        as_sub = (op_e == OP_SUBB) || (op_e == OP_CMP);
        as_cin = ((op_e == OP_ADDC) || (op_e == OP_SUBB)) ? cy_in : 1'b0;
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a     (acc_in),
        .b     (opnd_in),
        .cin   (as_cin),
        .sub   (as_sub),
        .res   (as_res),
        .c_top (as_ctop),
        .c_aux (as_caux),
        .c_ov  (as_cov)
    );

    alu8_decadj #(.W(W)) u_decadj (
        .a    (acc_in),
        .cy_i (cy_in),
        .ac_i (ac_in),
        .res  (da_res),
        .cy_o (da_cy)
    );

    alu8_muldiv #(.W(W)) u_muldiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (accept && is_md),
        .is_div   (op_e == OP_DIV),
        .opa      (acc_in),
        .opb      (b_in),
        .busy     (md_busy),
        .fin      (md_fin),
        .div_mode (md_div),
        .div_zero (md_dz),
        .res_hi   (md_hi),
        .res_lo   (md_lo)
    );

    // Next architectural state selection.
    always_comb begin
        acc_n     = acc_q;
        b_n       = b_q;
        flg_n     = flg_q;
        ac_hold_n = ac_hold_q;
        done_n    = 1'b0;
        if (md_fin) begin
            acc_n    = md_lo;
            b_n      = md_hi;
            flg_n.cy = 1'b0;
            flg_n.ac = ac_hold_q;
            flg_n.ov = md_div ? md_dz : (md_hi != '0);
            done_n   = 1'b1;
        end else if (accept) begin
            ac_hold_n = ac_in;
            done_n    = !is_md;
            case (op_e)
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    acc_n = as_res;
                    b_n   = b_in;
                    flg_n = '{cy: as_ctop, ac: as_caux, ov: as_cov};
                end
                OP_DECA: begin
                    acc_n = da_res;
                    b_n   = b_in;
                    flg_n = '{cy: da_cy, ac: ac_in, ov: ov_in};
                end
                OP_CMP: begin
                    acc_n = acc_in;
                    b_n   = b_in;
                    flg_n = '{cy: as_ctop, ac: ac_in, ov: ov_in};
                end
                OP_MUL, OP_DIV: begin
                    acc_n = acc_q;
                end
                default: begin
                    acc_n = acc_in;
                    b_n   = b_in;
                    flg_n = '{cy: cy_in, ac: ac_in, ov: ov_in};
                end
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            b_q       <= '0;
            flg_q     <= '0;
            ac_hold_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            acc_q     <= acc_n;
            b_q       <= b_n;
            flg_q     <= flg_n;
            ac_hold_q <= ac_hold_n;
            done_q    <= done_n;
        end
    end

    // Output drive; parity tracks the held accumulator.
    always_comb begin
        acc_out = acc_q;
        b_out   = b_q;
        cy_out  = flg_q.cy;
        ac_out  = flg_q.ac;
        ov_out  = flg_q.ov;
        par_out = ^acc_q;
        busy    = md_busy;
        done    = done_q;
    end

endmodule

// Property checker for alu8_unit, attached through bind.
// Assumes inputs are known whenever start is high.
module alu8_unit_chk #(
    parameter int W = alu8_pkg::DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [2:0]   op,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] opnd_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] acc_out,
    input logic [W-1:0] b_out,
    input logic         cy_out,
    input logic         ov_out,
    input logic         busy,
    input logic         done
);

    p_cmp_keeps_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd6) |=>
            (acc_out == $past(acc_in)) && (b_out == $past(b_in)) &&
            (cy_out == ($past(acc_in) < $past(opnd_in))));

    p_add_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd0) |=>
            (ov_out == (($past(acc_in[W-1]) == $past(opnd_in[W-1])) &&
                        (acc_out[W-1] != $past(acc_in[W-1])))));

    p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 3'd3 && op != 3'd4) |=> (done && !busy));

    p_hold_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(acc_out) && $stable(b_out)));

    p_no_done_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    p_muldiv_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !cy_out));

endmodule

bind alu8_unit alu8_unit_chk #(.W(W)) u_chk (.*);

// File: tb/alu8_unit_test.sv
// Self-checking bench: behavioural reference model updated on every rising edge,
// all outputs compared on every falling edge.
module alu8_unit_test;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] acc_in = '0, opnd_in = '0, b_in = '0;
    logic         cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic [W-1:0] acc_out, b_out;
    logic         cy_out, ac_out, ov_out, par_out, busy, done;

    int checks = 0;
    int errors = 0;

    alu8_unit #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in),
        .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .acc_out(acc_out), .b_out(b_out), .cy_out(cy_out), .ac_out(ac_out),
        .ov_out(ov_out), .par_out(par_out), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference state
    int e_acc = 0, e_b = 0, e_cy = 0, e_ac = 0, e_ov = 0, e_busy = 0, e_done = 0;
    string e_req = "R12";
    int p_left = 0, p_acc = 0, p_b = 0, p_cy = 0, p_ac = 0, p_ov = 0;
    string p_req = "R6";
    bit en = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, advances on the same edges as the design
    always @(posedge clk) begin
        int a, o, bb, c, x, y, t, c1;
        a = int'(acc_in); o = int'(opnd_in); bb = int'(b_in);
        c = int'(cy_in); x = int'(ac_in); y = int'(ov_in);
        if (!rst_n) begin
            e_acc = 0; e_b = 0; e_cy = 0; e_ac = 0; e_ov = 0;
            e_busy = 0; e_done = 0; p_left = 0; e_req = "R12"; en = 1;
        end else begin
            e_done = 0;
            if (p_left > 0) begin
                p_left--;
                if (p_left == 0) begin
                    e_acc = p_acc; e_b = p_b; e_cy = p_cy; e_ac = p_ac; e_ov = p_ov;
                    e_busy = 0; e_done = 1; e_req = p_req;
                end
            end else if (start) begin
                e_done = 1;
                case (int'(op))
                    0, 1: begin
                        if (op == 3'd0) c = 0;
                        t = a + o + c;
                        e_acc = t % 256; e_b = bb; e_cy = (t > 255);
                        e_ac = ((a % 16) + (o % 16) + c) > 15;
                        e_ov = (((a % 128) + (o % 128) + c) > 127) ^ e_cy;
                        e_req = (op == 3'd0) ? "R1/R2/R3" : "R1/R2/R3 addc";
                    end
                    2: begin
                        t = a - o - c;
                        e_acc = (t + 512) % 256; e_b = bb; e_cy = (t < 0);
                        e_ac = ((a % 16) - (o % 16) - c) < 0;
                        e_ov = (((a % 128) - (o % 128) - c) < 0) ^ e_cy;
                        e_req = "R5/R2/R3";
                    end
                    3: begin
                        t = a * bb;
                        p_acc = t % 256; p_b = t / 256; p_cy = 0; p_ac = x;
                        p_ov = (t > 255); p_req = "R6";
                        p_left = W; e_busy = 1; e_done = 0;
                    end
                    4: begin
                        if (bb == 0) begin p_acc = 255; p_b = a; p_ov = 1; end
                        else begin p_acc = a / bb; p_b = a % bb; p_ov = 0; end
                        p_cy = 0; p_ac = x; p_req = "R7";
                        p_left = W; e_busy = 1; e_done = 0;
                    end
                    5: begin
                        t = a;
                        if ((t % 16) > 9 || x) t = t + 6;
                        c1 = (t > 255); t = t % 256;
                        if ((t / 16) > 9 || c || c1) t = t + 96;
                        e_cy = c | c1 | (t > 255); e_acc = t % 256;
                        e_b = bb; e_ac = x; e_ov = y; e_req = "R8";
                    end
                    6: begin
                        e_cy = (a < o); e_acc = a; e_b = bb; e_ac = x; e_ov = y;
                        e_req = "R9";
                    end
                    default: begin
                        e_acc = a; e_b = bb; e_cy = c; e_ac = x; e_ov = y;
                        e_req = "R10";
                    end
                endcase
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (en) begin
            check(e_req, "acc_out", int'(acc_out), e_acc);
            check(e_req, "b_out", int'(b_out), e_b);
            check(e_req, "cy_out", int'(cy_out), e_cy);
            check(e_req, "ac_out", int'(ac_out), e_ac);
            check(e_req, "ov_out", int'(ov_out), e_ov);
            check("R4", "par_out", int'(par_out), $countones(e_acc[7:0]) % 2);
            check("R11", "busy", int'(busy), e_busy);
            check("R11", "done", int'(done), e_done);
        end
    end

    task automatic issue(input int o_code, input int a, input int o, input int bb,
                         input int c, input int x, input int y);
        @(negedge clk);
        start = 1'b1; op = 3'(o_code);
        acc_in = W'(a); opnd_in = W'(o); b_in = W'(bb);
        cy_in = c[0]; ac_in = x[0]; ov_in = y[0];
        @(negedge clk);
        start = 1'b0;
        if (o_code == 3 || o_code == 4) repeat (W + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R2 R3 add corners
        issue(0, 8'h7F, 8'h01, 8'h33, 1, 0, 0);
        issue(0, 8'hFF, 8'h01, 8'h00, 0, 0, 0);
        issue(0, 8'hC2, 8'hC2, 8'h00, 0, 1, 1);
        issue(1, 8'h10, 8'h20, 8'h44, 1, 0, 0);
        issue(1, 8'h0F, 8'h00, 8'h00, 1, 0, 0);
        // R5 subtract with borrow
        issue(2, 8'h00, 8'h01, 8'h00, 0, 0, 0);
        issue(2, 8'h80, 8'h01, 8'h00, 0, 0, 0);
        issue(2, 8'h50, 8'h50, 8'h00, 1, 0, 0);
        // R6 multiply
        issue(3, 8'h50, 8'h00, 8'hA0, 1, 1, 0);
        issue(3, 8'h0F, 8'h00, 8'h11, 1, 0, 1);
        // R7 divide, including divide by zero
        issue(4, 8'hFB, 8'h00, 8'h12, 1, 0, 1);
        issue(4, 8'h05, 8'h00, 8'h07, 0, 1, 0);
        issue(4, 8'hA5, 8'h00, 8'h00, 1, 0, 0);
        // R8 decimal adjust
        issue(5, 8'h9A, 8'h00, 8'h00, 0, 0, 0);
        issue(5, 8'h15, 8'h00, 8'h00, 0, 1, 0);
        issue(5, 8'h99, 8'h00, 8'h00, 0, 0, 1);
        issue(5, 8'hFA, 8'h00, 8'h00, 0, 0, 0);
        issue(5, 8'h23, 8'h00, 8'h00, 1, 0, 0);
        // R9 compare and R10 pass
        issue(6, 8'h10, 8'h20, 8'h55, 0, 1, 1);
        issue(6, 8'h20, 8'h20, 8'h55, 1, 0, 0);
        issue(7, 8'h3C, 8'h00, 8'hC3, 1, 1, 0);
        // R11 start ignored while busy
        @(negedge clk);
        start = 1'b1; op = 3'd3; acc_in = 8'hFF; b_in = 8'hFF;
        @(negedge clk);
        op = 3'd0; acc_in = 8'h01; opnd_in = 8'h02;
        repeat (4) @(negedge clk);
        start = 1'b0;
        repeat (W + 2) @(negedge clk);
        // mixed traffic, back-to-back requests
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            start = ($urandom_range(0, 2) != 0);
            op = 3'($urandom_range(0, 7));
            acc_in = W'($urandom); opnd_in = W'($urandom);
            b_in = ($urandom_range(0, 9) == 0) ? '0 : W'($urandom);
            cy_in = 1'($urandom); ac_in = 1'($urandom); ov_in = 1'($urandom);
        end
        @(negedge clk);
        start = 1'b0;
        repeat (W + 3) @(negedge clk);
        // R12 reset returns everything to zero
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule